// File: doc/BRIEF.md
# Bit-Banged Three-Wire Serial EEPROM Engine

This block emulates a 256-word, 16-bit serial EEPROM that a processor drives entirely by software. The processor writes a pin register in one address group: chip select, serial clock and a data-in bit. It reads the same group to get the data-out bit. Every pin write is compared with the previous pin state. Edges on chip select and serial clock then step a command engine. The engine collects a start bit, a two-bit opcode and an eight-bit word address, and then carries out single-word read, write and erase, bulk fill, bulk erase, or a change to the write-enable latch.

Writes, erases and bulk operations do not finish when their last bit is clocked in. They wait in a pending state, and the addressed word is stored on the next chip-select rising edge, provided writes are enabled. Chip-select edges are handled before serial-clock edges that arrive in the same register write. The serial clock acts whatever the level of chip select. The word array comes out of reset holding 0xFFFF everywhere.

Top module: `seep_top`

## Requirements
- R1: Only a write with busAddr[7:4] = 0x8 updates the pin register, which holds CS in bit 7, SK in bit 6 and data-in in bit 1. A write to any other group leaves the pin state and the engine unchanged.
- R2: A read with busAddr[7:4] = 0x8 returns the data-out bit in bit 0 and zeros in bits 7:1. A read of any other group returns 0x00.
- R3: On a CS rising edge, the pending state stores the low 16 bits of the shift value into the addressed word if writes are enabled. Data-out then reads 1 and the engine goes to null. In any other state, a CS rising edge moves the engine to idle.
- R4: In idle, an SK rise with data-in = 1 is the start bit. The next SK rises shift in two opcode bits and then eight address bits, most significant bit first.
- R5: The write-enable latch is disabled after reset. Opcode 00 with address bits [7:6] = 11 sets it and 00 clears it. Either one takes effect with no data phase, and the engine returns to null.
- R6: Opcode 01 takes 16 data bits, most significant first, and then waits for a CS rise before storing them. While writes are disabled, the word keeps its value.
- R7: Opcode 10 loads the addressed word on one further SK rise, and data-out reads 0 at that point. Each of the next 16 SK falls shifts out one bit, most significant first. After the 16th fall the engine returns to null.
- R8: Opcode 11 takes 16 dummy clocks and then stores 0xFFFF to the addressed word on the next CS rise, if writes are enabled.
- R9: Opcode 00 with address bits [7:6] = 01 takes 16 data bits and then writes that value to all 256 words, if writes are enabled.
- R10: Opcode 00 with address bits [7:6] = 10 takes 16 dummy bits and sets all 256 words to 0xFFFF, if writes are enabled. The CS rise that follows then stores the dummy bits into the addressed word.
- R11: After reset every word reads 0xFFFF and data-out reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Processor write strobe, one cycle per access |
| busAddr | input | 8 | Low byte of the processor address; bits 7:4 select the group |
| busWrData | input | 8 | Processor write data (pin values) |
| busRdData | output | 8 | Processor read data |

## Verification
The bench first writes a distinct arithmetic pattern to every one of the 256 words and reads each one back. A stuck or crossed address bit, a reversed bit order or an off-by-one in the bit count would each show up as a mismatch at a predictable word. Writes, erases and bulk fills are then repeated with the latch disabled and enabled. This separates the gating from the datapath, and a bulk operation is told apart from a single-word store by the value that only the addressed word receives. A foreign-group write is placed in the middle of a read-out. If the pin register took that write, the SK edge history would shift and the word read back would be corrupted.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [3:0] {
    ST_NULL, ST_IDLE, ST_OPC, ST_ADR, ST_SPECIAL,
    ST_WRDATA, ST_RDSETUP, ST_ERASE, ST_SHOUT, ST_PEND
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clearSr;
    logic loadWord;
    logic setOnes;
    logic setErased;
    logic shiftOut;
    logic commit;
    logic fillAll;
    logic eraseAll;
  } dpCtl_t;

endpackage

// File: rtl/seep_ctrl.sv
module seep_ctrl
  import seep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [7:0]        busAddr,
  input  logic [7:0]        busWrData,
  input  logic [7:0]        peekBits,
  output dpCtl_t            ctl,
  output logic              dinBit,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              wenLatch,
  output engState_e         engState,
  output logic [7:0]        pinReg
);
  localparam int CNT_W = $clog2(DATA_W + 1) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bitCnt, bitCntNext, cntInc;
  logic [1:0] opc, opcNext;
  logic [ADDR_W-1:0] adrNext;
  logic wenNext;
  engState_e stMid, stNext;
  logic pinWr, csRise, skRise, skFall;

  assign pinWr  = busWr && (busAddr[7:4] == 4'h8);
  assign csRise = pinWr && busWrData[7] && !pinReg[7];
  assign skRise = pinWr && busWrData[6] && !pinReg[6];
  assign skFall = pinWr && !busWrData[6] && pinReg[6];
  assign dinBit = busWrData[1];
  assign cntInc = bitCnt + 1'b1;

  always_comb begin
    ctl = '0;
    stMid = engState;
    bitCntNext = bitCnt;
    opcNext = opc;
    adrNext = wordAddr;
    wenNext = wenLatch;
    if (csRise) begin
      if (engState == ST_PEND) begin
        ctl.commit  = wenLatch;
        ctl.setOnes = 1'b1;
        stMid = ST_NULL;
      end else begin
        stMid = ST_IDLE;
      end
    end
    stNext = stMid;
    if (skRise) begin
      if (stMid != ST_NULL && stMid != ST_IDLE && stMid != ST_SHOUT) begin
        ctl.shiftIn = 1'b1;
        bitCntNext = cntInc;
      end
      case (stMid)
        ST_IDLE: if (dinBit) begin
          stNext = ST_OPC; ctl.clearSr = 1'b1; bitCntNext = '0;
        end
        ST_OPC: if (cntInc == 2) begin
          stNext = ST_ADR; bitCntNext = '0; opcNext = peekBits[1:0];
        end
        ST_ADR: if (cntInc == 8) begin
          bitCntNext = '0;
          adrNext = peekBits[ADDR_W-1:0];
          case (opc)
            2'b00: begin
              stNext = ST_SPECIAL;
              if (peekBits[7:6] == 2'b00) begin wenNext = 1'b0; stNext = ST_NULL; end
              if (peekBits[7:6] == 2'b11) begin wenNext = 1'b1; stNext = ST_NULL; end
            end
            2'b01: stNext = ST_WRDATA;
            2'b10: stNext = ST_RDSETUP;
            default: stNext = ST_ERASE;
          endcase
        end
        ST_SPECIAL: if (cntInc == FULL) begin
          bitCntNext = '0;
          case (wordAddr[ADDR_W-1 -: 2])
            2'b01: begin ctl.fillAll = wenLatch; stNext = ST_PEND; end
            2'b10: begin ctl.eraseAll = wenLatch; stNext = ST_PEND; end
            default: stNext = ST_NULL;
          endcase
        end
        ST_WRDATA: if (cntInc == FULL) begin
          bitCntNext = '0; stNext = ST_PEND;
        end
        ST_RDSETUP: if (cntInc == 1) begin
          bitCntNext = '0; ctl.loadWord = 1'b1; stNext = ST_SHOUT;
        end
        ST_ERASE: if (cntInc == FULL) begin
          bitCntNext = '0; ctl.setErased = 1'b1; stNext = ST_PEND;
        end
        default: ;
      endcase
    end else if (skFall && stMid == ST_SHOUT) begin
      ctl.shiftOut = 1'b1;
      bitCntNext = cntInc;
      if (cntInc == FULL) begin
        bitCntNext = '0; stNext = ST_NULL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engState <= ST_NULL;
      bitCnt   <= '0;
      opc      <= '0;
      wordAddr <= '0;
      wenLatch <= 1'b0;
      pinReg   <= '0;
    end else begin
      engState <= stNext;
      bitCnt   <= bitCntNext;
      opc      <= opcNext;
      wordAddr <= adrNext;
      wenLatch <= wenNext;
      if (pinWr) pinReg <= {busWrData[7:1], 1'b0};
    end
  end

endmodule

// File: rtl/seep_dp.sv
module seep_dp
  import seep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              dinBit,
  input  logic [ADDR_W-1:0] wordAddr,
  output logic [7:0]        peekBits,
  output logic              dataOut
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int SR_W  = DATA_W + 1;

  logic [SR_W-1:0] sr, srShift, srNext;
  logic [DATA_W-1:0] mem [WORDS];

  assign srShift  = {sr[SR_W-2:0], dinBit};
  assign peekBits = srShift[7:0];
  assign dataOut  = sr[SR_W-1];

  always_comb begin
    srNext = sr;
    if (ctl.setOnes)        srNext = '1;
    else if (ctl.clearSr)   srNext = '0;
    else if (ctl.loadWord)  srNext = {1'b0, mem[wordAddr]};
    else if (ctl.setErased) srNext = {1'b0, {DATA_W{1'b1}}};
    else if (ctl.shiftIn)   srNext = srShift;
    else if (ctl.shiftOut)  srNext = {sr[SR_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      sr <= srNext;
      if (ctl.commit) begin
        mem[wordAddr] <= sr[DATA_W-1:0];
      end else if (ctl.fillAll) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= srShift[DATA_W-1:0];
      end else if (ctl.eraseAll) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      end
    end
  end

endmodule

// File: rtl/seep_top.sv
module seep_top
  import seep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [7:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData
);
  dpCtl_t ctl;
  logic dinBit, dataOut, wenLatch;
  logic [7:0] peekBits, pinReg;
  logic [ADDR_W-1:0] wordAddr;
  engState_e engState;

  seep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .peekBits(peekBits), .ctl(ctl), .dinBit(dinBit),
    .wordAddr(wordAddr), .wenLatch(wenLatch), .engState(engState), .pinReg(pinReg)
  );

  seep_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dinBit(dinBit),
    .wordAddr(wordAddr), .peekBits(peekBits), .dataOut(dataOut)
  );

  assign busRdData = (busAddr[7:4] == 4'h8) ? {7'b0, dataOut} : 8'h00;

endmodule

// File: rtl/seep_chk.sv
module seep_chk
  import seep_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic [7:0] busAddr,
  input logic [7:0] busWrData,
  input logic       dataOut,
  input logic       wenLatch,
  input engState_e  engState,
  input logic [7:0] pinReg
);
  logic pinWr;
  assign pinWr = busWr && (busAddr[7:4] == 4'h8);

  // R1
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinWr |=> $stable(dataOut));

  // R1
  state_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinWr |=> ($stable(engState) && $stable(pinReg)));

  // R5
  wen_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinWr |=> $stable(wenLatch));

  // R5
  wen_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wenLatch) |-> $past(busWr && busWrData[6]));

  // R3
  commit_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinWr && busWrData[7] && !pinReg[7] && engState == ST_PEND)
      |=> (dataOut && engState == ST_NULL));

endmodule

bind seep_top seep_chk u_chk (.*);

// File: tb/sim_seep_top.sv
module sim_seep_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [7:0] busAddr = 8'h80;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] model [256];

  seep_top u0 (.clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
               .busWrData(busWrData), .busRdData(busRdData));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic cs, input logic sk, input logic di);
    @(negedge clk);
    busWr = 1'b1; busAddr = 8'h80; busWrData = {cs, sk, 4'b0, di, 1'b0};
    @(posedge clk); #1 busWr = 1'b0;
  endtask

  task automatic getDout(output logic d);
    @(negedge clk); busAddr = 8'h80; #1 d = busRdData[0];
  endtask

  task automatic sendBit(input logic b);
    pins(1'b1, 1'b0, b); pins(1'b1, 1'b1, b);
  endtask

  task automatic header(input logic [1:0] opc, input logic [7:0] adr);
    pins(0, 0, 0); pins(1, 0, 0);
    sendBit(1'b1);
    sendBit(opc[1]); sendBit(opc[0]);
    for (int i = 7; i >= 0; i--) sendBit(adr[i]);
  endtask

  task automatic commitSeq(input string tag);
    logic d;
    pins(0, 0, 0); pins(1, 0, 0);
    getDout(d);
    check(tag, {15'b0, d}, 16'h0001); // R3: data-out reads 1 after commit
    pins(0, 0, 0);
  endtask

  task automatic readWord(input logic [7:0] adr, output logic [15:0] w, input bit poke);
    logic d;
    header(2'b10, adr);
    sendBit(1'b0);
    getDout(d);
    check("R7 dout after load", {15'b0, d}, 16'h0000);
    for (int k = 1; k <= 16; k++) begin
      pins(1, 0, 0);
      getDout(d);
      w[16-k] = d;
      if (poke && k == 4) begin
        // R1: foreign-group write that would be an SK rise plus a CS fall
        @(negedge clk); busWr = 1'b1; busAddr = 8'h40; busWrData = 8'h40;
        @(posedge clk); #1 busWr = 1'b0;
        @(negedge clk); #1 check("R2 other group read", {8'h00, busRdData}, 16'h0000);
      end
      pins(1, 1, 0);
    end
    pins(0, 0, 0);
  endtask

  task automatic sendWord(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic special(input logic [7:0] adr);
    header(2'b00, adr); pins(0, 0, 0);
  endtask

  task automatic verifyAll(input string tag, input int stepSz);
    logic [15:0] w;
    for (int a = 0; a < 256; a += stepSz) begin
      readWord(a[7:0], w, 1'b0);
      check(tag, w, model[a]);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 257) ^ 16'h3C96 ^ (a << 11));
  endfunction

  initial begin
    logic [15:0] w;
    logic d;
    for (int a = 0; a < 256; a++) model[a] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    getDout(d);
    check("R11 dout after reset", {15'b0, d}, 16'h0000);
    check("R2 read format", {8'h00, busRdData}, 16'h0000);
    verifyAll("R11 reset contents", 17);

    // R6: write while latch disabled leaves word untouched
    header(2'b01, 8'h12); sendWord(16'h1234); commitSeq("R3 commit disabled");
    readWord(8'h12, w, 1'b0); check("R6 disabled write", w, model[8'h12]);

    // R5: enable, then sweep every address with a distinct pattern (R4, R6, R7)
    special(8'hC0);
    for (int a = 0; a < 256; a++) begin
      header(2'b01, a[7:0]); sendWord(pat(a)); commitSeq("R3 commit");
      model[a] = pat(a);
    end
    verifyAll("R4 R6 R7 sweep", 1);

    // R1: foreign write mid read-out must not disturb the shift sequence
    readWord(8'h5A, w, 1'b1); check("R1 foreign write ignored", w, model[8'h5A]);

    // R8: single erase
    header(2'b11, 8'h03); sendWord(16'h0000); commitSeq("R3 commit erase");
    model[3] = 16'hFFFF;
    readWord(8'h03, w, 1'b0); check("R8 erased word", w, 16'hFFFF);
    readWord(8'h04, w, 1'b0); check("R8 neighbour kept", w, model[4]);

    // R5: disable, erase and write have no effect
    special(8'h00);
    header(2'b11, 8'h07); sendWord(16'h0000); commitSeq("R3 commit disabled erase");
    readWord(8'h07, w, 1'b0); check("R5 disabled erase", w, model[7]);
    header(2'b00, 8'h40); sendWord(16'h0F0F); commitSeq("R3 commit disabled fill");
    verifyAll("R9 disabled fill", 37);

    // R9: fill all while enabled
    special(8'hFF);
    header(2'b00, 8'h40); sendWord(16'h5AA5); commitSeq("R3 commit fill");
    for (int a = 0; a < 256; a++) model[a] = 16'h5AA5;
    verifyAll("R9 fill all", 5);

    // R10: erase all; the CS commit then stores the dummy bits at 0x80
    header(2'b00, 8'h80); sendWord(16'h0000); commitSeq("R3 commit erase all");
    for (int a = 0; a < 256; a++) model[a] = 16'hFFFF;
    model[8'h80] = 16'h0000;
    verifyAll("R10 erase all", 8);
    readWord(8'h81, w, 1'b0); check("R10 erase all neighbour", w, 16'hFFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule